// File: doc/BRIEF.md
# External Bus Cycle Wait-State Controller

This block runs single read and write cycles on an external memory port for a processor core with a 24-bit data path. The core presents a request with an address, a direction bit, a memory-type bit and write data. When the controller is idle and this side owns the bus, it accepts the request. It then drives one active-low strobe, read or write, and holds the cycle open. The cycle lasts at least a programmed number of wait states.

An external transfer-acknowledge input, active low, can lengthen any cycle programmed with one or more wait states. The cycle ends one clock after acknowledge is first sampled low, or after the programmed minimum, whichever comes later. Cycles with zero wait states programmed ignore acknowledge, and so do cycles marked as DRAM-type. When the cycle ends, the controller returns read data to the core with a one-clock done pulse.

Strobe and data-bus enables follow bus ownership, which models tri-stating. Bus arbitration, DRAM row and column sequencing and acknowledge synchronization are handled elsewhere.

Top module: `ext_bus_wait_ctrl`

## Requirements
- R1: After reset, rd_n and wr_n are 1, done is 0, rdata is 0, and req_ready equals bus_owner.
- R2: req_ready is 1 exactly when no cycle is active and bus_owner is 1. A request (req_valid=1) is accepted only on a clock where req_ready is 1. A request held while busy waits for the current cycle to finish.
- R3: At most one strobe is low at a time. rd_n is used when req_write=0 and wr_n when req_write=1. The strobe goes low on the clock after acceptance and stays low through the last clock of the cycle.
- R4: With wait_cfg=0 the strobe is low for exactly one clock, whatever the value of ack_n.
- R5: With wait_cfg=W>0 on a non-DRAM cycle, the strobe is low for max(W+1, K+2) clocks. K is the index of the first strobe clock (counting from 0) in which ack_n is sampled 0 while bus_owner is 1.
- R6: Holding ack_n at 1 keeps a cycle with W>0 open indefinitely (tested over 40 clocks).
- R7: An ack_n of 0 has no effect while idle, including on the acceptance clock. It also has no effect while bus_owner is 0.
- R8: A cycle accepted with req_dram=1 ignores ack_n. Its strobe is low for exactly wait_cfg+1 clocks.
- R9: done is high for exactly one clock, the clock after the last strobe clock, with both strobes high. For a read, rdata then holds data_in as sampled on the last strobe clock. A write leaves rdata unchanged.
- R10: strobe_oe equals bus_owner. data_oe is 1 only while a write cycle is active and bus_owner is 1. addr_out and data_out hold the accepted address and write data for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core requests a cycle |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dram | input | 1 | 1 = DRAM-type cycle, acknowledge not used |
| req_addr | input | 24 | Cycle address |
| req_wdata | input | 24 | Write data |
| wait_cfg | input | 4 | Minimum wait states, 0 to 15, latched at acceptance |
| bus_owner | input | 1 | This side currently owns the external bus |
| ack_n | input | 1 | Transfer acknowledge, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| strobe_oe | output | 1 | Output enable for the strobes |
| addr_out | output | 24 | External address |
| data_out | output | 24 | External write data |
| data_oe | output | 1 | Output enable for the data bus |
| data_in | input | 24 | External read data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 24 | Read data returned to the core |

## Verification
Cycles run with wait counts 0, 1, 3, 4 and 15, and with acknowledge arriving early, just at the minimum, one clock past the minimum, or very late. These cases show whether the length comes from the count or from the acknowledge, and expose off-by-one errors in the acknowledge delay. Acknowledge is also held low during idle, on the acceptance clock and while ownership is withdrawn, and is driven on zero-wait and DRAM-type cycles; each of these must leave the cycle length unchanged. A changing data_in pattern and a back-to-back request held during a busy cycle pin down the read-capture clock and the accept handshake.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
    localparam int DEF_ADDR_W = 24;
    localparam int DEF_DATA_W = 24;
    localparam int DEF_WS_W   = 4;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } phase_e;
endpackage

// File: rtl/ebw_wait_counter.sv
module ebw_wait_counter #(
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WS_W-1:0] limit_in,
    input  logic            step,
    output logic            min_met,
    output logic            limit_zero
);
    localparam logic [WS_W-1:0] CNT_MAX = {WS_W{1'b1}};

    typedef struct packed {
        logic [WS_W-1:0] cnt;
        logic [WS_W-1:0] lim;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.cnt = '0;
            s_d.lim = limit_in;
        end else if (step && (s_q.cnt != CNT_MAX)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign min_met    = (s_q.cnt >= s_q.lim);
    assign limit_zero = (s_q.lim == '0);
endmodule

// File: rtl/ebw_ack_tracker.sv
module ebw_ack_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample_en,
    input  logic ack_n,
    output logic seen
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d = seen_q;
        if (clear)                   seen_d = 1'b0;
        else if (sample_en && !ack_n) seen_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end

    assign seen = seen_q;
endmodule

// File: rtl/ext_bus_wait_ctrl.sv
module ext_bus_wait_ctrl
    import ebw_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int WS_W   = DEF_WS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_dram,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [WS_W-1:0]   wait_cfg,
    input  logic              bus_owner,
    input  logic              ack_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              strobe_oe,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic [DATA_W-1:0] data_in,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        phase_e            phase;
        logic              write;
        logic              dram;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } ctl_state_t;

    ctl_state_t s_d, s_q;

    logic accept;
    logic active;
    logic finish;
    logic min_met;
    logic limit_zero;
    logic ack_seen;
    logic step_cnt;
    logic ack_sample;

    assign active     = (s_q.phase == PH_ACTIVE);
    assign req_ready  = !active && bus_owner;
    assign accept     = req_valid && req_ready;
    assign finish     = active && min_met && (limit_zero || s_q.dram || ack_seen);
    assign step_cnt   = active && !finish;
    assign ack_sample = active && !finish && bus_owner && !s_q.dram;

    ebw_wait_counter #(.WS_W(WS_W)) u_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .limit_in   (wait_cfg),
        .step       (step_cnt),
        .min_met    (min_met),
        .limit_zero (limit_zero)
    );

    ebw_ack_tracker u_ack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sample_en (ack_sample),
        .ack_n     (ack_n),
        .seen      (ack_seen)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (accept) begin
            s_d.phase = PH_ACTIVE;
            s_d.write = req_write;
            s_d.dram  = req_dram;
            s_d.addr  = req_addr;
            s_d.wdata = req_wdata;
        end else if (finish) begin
            s_d.phase = PH_IDLE;
            s_d.done  = 1'b1;
            if (!s_q.write) s_d.rdata = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_n      = !(active && !s_q.write);
    assign wr_n      = !(active && s_q.write);
    assign strobe_oe = bus_owner;
    assign data_oe   = bus_owner && active && s_q.write;
    assign addr_out  = s_q.addr;
    assign data_out  = s_q.wdata;
    assign done      = s_q.done;
    assign rdata     = s_q.rdata;
endmodule

// File: rtl/ebw_checker.sv
module ebw_checker #(
    parameter int WS_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_write,
    input logic            req_dram,
    input logic [WS_W-1:0] wait_cfg,
    input logic            bus_owner,
    input logic            rd_n,
    input logic            wr_n,
    input logic            strobe_oe,
    input logic            data_oe,
    input logic            done
);
    logic acc;
    assign acc = req_valid && req_ready;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R3

    AST_STROBE_START: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ($past(req_write) ? !wr_n : !rd_n)); // R3

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready); // R2

    AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && wait_cfg == '0) |=> ##1 done); // R4

    AST_DRAM_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_dram && wait_cfg == 1) |=> ##2 done); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n && $past(!rd_n || !wr_n))); // R9

    AST_OE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_owner |-> (!strobe_oe && !data_oe)); // R10
endmodule

bind ext_bus_wait_ctrl ebw_checker #(.WS_W(WS_W)) u_ebw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_dram  (req_dram),
    .wait_cfg  (wait_cfg),
    .bus_owner (bus_owner),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .strobe_oe (strobe_oe),
    .data_oe   (data_oe),
    .done      (done)
);

// File: tb/test_ext_bus_wait_ctrl.sv
`timescale 1ns/1ps
module test_ext_bus_wait_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_dram = 1'b0;
    logic [23:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic [3:0]  wait_cfg = '0;
    logic        bus_owner = 1'b1;
    logic        ack_n = 1'b1;
    logic        rd_n, wr_n, strobe_oe, data_oe, done;
    logic [23:0] addr_out, data_out, rdata;
    logic [23:0] data_in = 24'h100000;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    // behavioural reference state
    bit          m_busy = 0;
    int          m_cnt = 0;
    int          m_w = 0;
    bit          m_ack = 0;
    bit          m_write = 0;
    bit          m_dram = 0;
    logic [23:0] m_addr = '0;
    logic [23:0] m_wdata = '0;
    bit          m_done = 0;
    logic [23:0] m_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_bus_wait_ctrl i_ext_bus_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_dram(req_dram), .req_addr(req_addr),
        .req_wdata(req_wdata), .wait_cfg(wait_cfg), .bus_owner(bus_owner),
        .ack_n(ack_n), .rd_n(rd_n), .wr_n(wr_n), .strobe_oe(strobe_oe),
        .addr_out(addr_out), .data_out(data_out), .data_oe(data_oe),
        .data_in(data_in), .done(done), .rdata(rdata)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R3", "rd_n", {31'b0, rd_n}, {31'b0, !(m_busy && !m_write)});
        chk("R3", "wr_n", {31'b0, wr_n}, {31'b0, !(m_busy && m_write)});
        chk("R2", "req_ready", {31'b0, req_ready}, {31'b0, !m_busy && bus_owner});
        chk("R9", "done", {31'b0, done}, {31'b0, m_done});
        chk("R9", "rdata", {8'b0, rdata}, {8'b0, m_rdata});
        chk("R10", "strobe_oe", {31'b0, strobe_oe}, {31'b0, bus_owner});
        chk("R10", "data_oe", {31'b0, data_oe}, {31'b0, bus_owner && m_busy && m_write});
        if (m_busy) begin
            chk("R10", "addr_out", {8'b0, addr_out}, {8'b0, m_addr});
            chk("R10", "data_out", {8'b0, data_out}, {8'b0, m_wdata});
        end
    endtask

    task automatic tick();
        bit fin;
        @(posedge clk);
        if (m_busy) begin
            fin = (m_cnt >= m_w) && (m_w == 0 || m_dram || m_ack);
            m_done = 0;
            if (fin) begin
                m_busy = 0;
                m_done = 1;
                if (!m_write) m_rdata = data_in;
            end else begin
                if (m_cnt < 15) m_cnt++;
                if (bus_owner && !ack_n && !m_dram) m_ack = 1;
            end
        end else begin
            m_done = 0;
            if (req_valid && bus_owner) begin
                m_busy = 1; m_cnt = 0; m_ack = 0; m_w = int'(wait_cfg);
                m_write = req_write; m_dram = req_dram;
                m_addr = req_addr; m_wdata = req_wdata;
            end
        end
        #1;
        compare_all();
        data_in = data_in + 24'h000135;
    endtask

    // one cycle: ack driven low from strobe clock ack_at onward (-1: never)
    task automatic do_cycle(input bit wr, input bit dr, input int w, input int ack_at,
                            input int exp_len, input string req);
        int len = 0;
        int k = 0;
        req_write = wr; req_dram = dr; wait_cfg = 4'(w);
        req_addr  = 24'hA00000 + 24'(w * 16 + ack_at + 1);
        req_wdata = 24'h5A0000 ^ 24'(exp_len);
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        while (!done && k < 300) begin
            ack_n = (ack_at >= 0 && k >= ack_at) ? 1'b0 : 1'b1;
            if (!rd_n || !wr_n) len++;
            tick();
            k++;
        end
        ack_n = 1'b1;
        chk(req, "strobe length", 32'(len), 32'(exp_len));
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 2 + 3);
        // R1: reset state
        chk("R1", "rd_n reset", {31'b0, rd_n}, 32'd1);
        chk("R1", "wr_n reset", {31'b0, wr_n}, 32'd1);
        chk("R1", "done reset", {31'b0, done}, 32'd0);
        chk("R1", "rdata reset", {8'b0, rdata}, 32'd0);
        chk("R1", "req_ready reset", {31'b0, req_ready}, 32'd1);
        rst_n = 1'b1;
        tick(); tick();

        // R4: zero wait, with and without ack
        do_cycle(0, 0, 0, -1, 1, "R4");
        do_cycle(1, 0, 0, 0, 1, "R4");
        // R5: minimum dominates, equal, ack one past
        do_cycle(0, 0, 3, 0, 4, "R5");
        do_cycle(0, 0, 4, 3, 5, "R5");
        do_cycle(1, 0, 4, 4, 6, "R5");
        do_cycle(0, 0, 1, 5, 7, "R5");
        do_cycle(0, 0, 15, 0, 16, "R5");
        // R6: long extension
        do_cycle(0, 0, 2, 40, 42, "R6");
        // R8: DRAM-type ignores ack
        do_cycle(0, 1, 5, -1, 6, "R8");
        do_cycle(1, 1, 2, 0, 3, "R8");

        // R7: ack low while idle and on the acceptance clock has no effect
        ack_n = 1'b0;
        tick(); tick(); tick();
        do_cycle(0, 0, 2, 6, 8, "R7");

        // R7: ack ignored while ownership is withdrawn
        req_write = 0; req_dram = 0; wait_cfg = 4'd2; req_addr = 24'h0BEEF0;
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        bus_owner = 1'b0; ack_n = 1'b0;
        for (int i = 0; i < 5; i++) tick();
        bus_owner = 1'b1; ack_n = 1'b1;
        tick(); tick();
        chk("R7", "cycle still open", {31'b0, rd_n}, 32'd0);
        ack_n = 1'b0;
        tick(); tick();
        ack_n = 1'b1;
        tick();
        chk("R7", "cycle closed after ack", {31'b0, rd_n}, 32'd1);
        tick();

        // R2: request held during a busy cycle waits, then is taken
        req_write = 1; req_dram = 0; wait_cfg = 4'd1; req_wdata = 24'h123456;
        req_addr = 24'h00C0DE; ack_n = 1'b0; req_valid = 1'b1;
        for (int i = 0; i < 14; i++) tick();
        req_valid = 1'b0; ack_n = 1'b1;
        for (int i = 0; i < 6; i++) tick();
        chk("R2", "idle after back-to-back", {31'b0, req_ready}, 32'd1);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule